// File: doc/BRIEF.md
# Counter-Ramp ADC Controller

This block sequences a single-slope (counter-ramp) analog-to-digital conversion. A start request opens a sampling window in which an external track-and-hold follows the analog input. The block then freezes the sample and steps an external DAC upward one code per clock, beginning at zero. An external comparator reports, high, that the DAC level is still below the held input. The block counts clock cycles until that report falls. It then latches the count as the result and pulses a done strobe.

The comparator result is asynchronous to the clock, so it passes through a flop synchronizer of `SYNC_STAGES` stages. The ramp counter runs that many codes ahead of the comparator decision it is looking at, and the captured result is reduced by the same amount. The synchronized comparator level inside the ramp window is also driven out as a pulse. The width of that pulse in clocks equals the conversion value, so a downstream timer or filter can use it directly. Conversion time grows with the input level, up to about 2^WIDTH clocks for a full-scale input.

The controller moves through five named states in a fixed order: `ST_IDLE` → `ST_SAMPLE` (on start) → `ST_HOLD` (after `SAMPLE_CLKS` cycles) → `ST_RAMP` (after one settling cycle) → `ST_DONE` (on ramp end) → `ST_IDLE` (always, after one cycle).

Top module: `adc_ramp_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is 0: DAC code, sample, hold, busy, done, result and pulse.
- R2: A start request seen in idle raises `sample_o` in the following cycle and holds it for exactly `SAMPLE_CLKS` consecutive cycles. No other cycle of a conversion drives it high.
- R3: `hold_o` rises in the cycle after sampling ends and stays high through the last ramp cycle. It is low in the done cycle, and it is never high together with `sample_o`.
- R4: `dac_code_o` is 0 outside the ramp. In the ramp it starts at 0 and rises by exactly one per clock, and it stays at the all-ones code if the ramp runs past it.
- R5: With `SYNC_STAGES` = 2, the result equals the number of DAC codes that lie below the held input (codes c with input > c). This is the input level v for any v up to 2^WIDTH-1.
- R6: If the comparator never falls (input above every code), the conversion still ends and reports the all-ones code.
- R7: Across one conversion, `pwm_o` is high for min(v, 2^WIDTH) clock cycles, all within the ramp.
- R8: `done_o` is a single-cycle strobe. Counting the clock edge that accepts the start as edge 0, it is high in cycle SAMPLE_CLKS + r + 3 + SYNC_STAGES, where r = min(v, 2^WIDTH-1). `busy_o` is high from cycle 1 through that done cycle and low afterwards.
- R9: A start request while busy is ignored. The running conversion keeps its timing and result, and no new conversion follows it.
- R10: `result_o` changes only in the cycle where `done_o` is high. It keeps its value through idle time and through the whole of the next conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a conversion; acted on only in idle |
| cmp_i | input | 1 | Asynchronous comparator result, high while the DAC level is below the held input |
| dac_code_o | output | WIDTH | Code for the external ramp DAC |
| sample_o | output | 1 | High while the track-and-hold should follow the input |
| hold_o | output | 1 | High while the held input must stay frozen |
| busy_o | output | 1 | High from start acceptance through the done cycle |
| done_o | output | 1 | One-cycle strobe marking a new result |
| result_o | output | WIDTH | Last completed conversion value |
| pwm_o | output | 1 | Synchronized comparator window; high-time equals the conversion value |

## Verification
An off-by-one in the ramp counter or in the synchronizer correction shifts every result and every done time by the same constant. A sweep over all input levels exposes this in the first conversion. A sampling counter that stops late or early shows at once as a wrong `sample_o` width. Because the bench's hold model also tracks the input while `sample_o` is high, a late stop also latches a value that was changed on purpose after the window, and this corrupts the result. A state machine that reacts to start while busy either stretches the running conversion or leaves `busy_o` high after done; both appear within a few cycles of the done strobe. A result register that updates outside the done cycle is caught while the next conversion is still running.

// File: rtl/adc_ramp_pkg.sv
package adc_ramp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SAMPLE = 3'd1,
        ST_HOLD   = 3'd2,
        ST_RAMP   = 3'd3,
        ST_DONE   = 3'd4
    } conv_state_t;

endpackage

// File: rtl/adc_cmp_sync.sv
module adc_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/adc_ramp_counter.sv
module adc_ramp_counter #(
    parameter int WIDTH = 8,
    parameter int CW    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic [CW-1:0]    cnt_o,
    output logic [WIDTH-1:0] dac_code_o
);

    localparam logic [CW-1:0]    TOP_C   = CW'((1 << WIDTH) - 1);
    localparam logic [WIDTH-1:0] ALL_ONE = {WIDTH{1'b1}};

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (run_i) cnt_q <= cnt_q + 1'b1;
        else            cnt_q <= '0;
    end

    always_comb begin
        if (!run_i)              dac_code_o = '0;
        else if (cnt_q >= TOP_C) dac_code_o = ALL_ONE;
        else                     dac_code_o = cnt_q[WIDTH-1:0];
    end

    assign cnt_o = cnt_q;

    // R4: consecutive ramp cycles step the DAC by one until all-ones
    a_r4_dac_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && $past(dac_code_o) != ALL_ONE)
            |-> dac_code_o == $past(dac_code_o) + 1'b1);

    // R4: once saturated the code does not wrap while the ramp runs
    a_r4_dac_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && $past(dac_code_o) == ALL_ONE)
            |-> dac_code_o == ALL_ONE);

endmodule

// File: rtl/adc_ramp_fsm.sv
module adc_ramp_fsm
    import adc_ramp_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SAMPLE_CLKS = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CW          = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_s_i,
    input  logic [CW-1:0]    ramp_cnt_i,
    output logic             run_o,
    output logic             sample_o,
    output logic             hold_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             pwm_o,
    output logic [WIDTH-1:0] result_o
);

    localparam int            SW       = (SAMPLE_CLKS > 1) ? $clog2(SAMPLE_CLKS) : 1;
    localparam logic [SW-1:0] SMP_LAST = SW'(SAMPLE_CLKS - 1);
    localparam logic [CW-1:0] SYNC_C   = CW'(SYNC_STAGES);
    localparam logic [CW-1:0] TOP_C    = CW'((1 << WIDTH) - 1);

    conv_state_t      state_q, state_d;
    logic [SW-1:0]    smp_q;
    logic [WIDTH-1:0] result_q;
    logic [CW-1:0]    code_seen;
    logic             ramp_valid;
    logic             ramp_end;

    // the comparator level now visible was produced SYNC_STAGES codes ago
    assign code_seen  = ramp_cnt_i - SYNC_C;
    assign ramp_valid = (state_q == ST_RAMP) && (ramp_cnt_i >= SYNC_C);
    assign ramp_end   = ramp_valid && (!cmp_s_i || code_seen == TOP_C);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)            state_d = ST_SAMPLE;
            ST_SAMPLE: if (smp_q == SMP_LAST)  state_d = ST_HOLD;
            ST_HOLD:                           state_d = ST_RAMP;
            ST_RAMP:   if (ramp_end)           state_d = ST_DONE;
            ST_DONE:                           state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // sampling window length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  smp_q <= '0;
        else if (state_q != ST_SAMPLE) smp_q <= '0;
        else                         smp_q <= smp_q + 1'b1;
    end

    // result capture on ramp end only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        result_q <= '0;
        else if (ramp_end) result_q <= code_seen[WIDTH-1:0];
    end

    // outputs
    always_comb begin
        run_o    = 1'b0;
        sample_o = 1'b0;
        hold_o   = 1'b0;
        busy_o   = 1'b1;
        done_o   = 1'b0;
        pwm_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o   = 1'b0;
            ST_SAMPLE: sample_o = 1'b1;
            ST_HOLD:   hold_o   = 1'b1;
            ST_RAMP: begin
                hold_o = 1'b1;
                run_o  = 1'b1;
                pwm_o  = ramp_valid && cmp_s_i;
            end
            ST_DONE:   done_o   = 1'b1;
            default:   busy_o   = 1'b0;
        endcase
    end

    assign result_o = result_q;

    // R8: done never lasts two cycles
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: sampling and holding are mutually exclusive
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_o && hold_o));

    // R10: the result register moves only into the done cycle
    a_r10_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_q) |-> state_q == ST_DONE);

    // R9: a start during the ramp does not restart sampling
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && start_i) |=> state_q != ST_SAMPLE);

    // R3: hold follows directly on the end of sampling
    a_r3_hold_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_o) |-> hold_o);

endmodule

// File: rtl/adc_ramp_ctrl.sv
module adc_ramp_ctrl #(
    parameter int WIDTH       = 8,
    parameter int SAMPLE_CLKS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             sample_o,
    output logic             hold_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o,
    output logic             pwm_o
);

    localparam int CW = $clog2((1 << WIDTH) + SYNC_STAGES + 1);

    logic          cmp_s;
    logic          run;
    logic [CW-1:0] ramp_cnt;

    adc_cmp_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cmp_i),
        .q_o   (cmp_s)
    );

    adc_ramp_counter #(
        .WIDTH (WIDTH),
        .CW    (CW)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .cnt_o      (ramp_cnt),
        .dac_code_o (dac_code_o)
    );

    adc_ramp_fsm #(
        .WIDTH       (WIDTH),
        .SAMPLE_CLKS (SAMPLE_CLKS),
        .SYNC_STAGES (SYNC_STAGES),
        .CW          (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .cmp_s_i    (cmp_s),
        .ramp_cnt_i (ramp_cnt),
        .run_o      (run),
        .sample_o   (sample_o),
        .hold_o     (hold_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .pwm_o      (pwm_o),
        .result_o   (result_o)
    );

    // R4: the DAC rests at zero whenever the input is not frozen
    a_r4_dac_rest: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_o |-> dac_code_o == '0);

    // R7: the pulse output only appears while the sample is held
    a_r7_pwm_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_o |-> hold_o);

    // R8: busy covers every active phase
    a_r8_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o || hold_o || done_o) |-> busy_o);

endmodule

// File: tb/adc_ramp_ctrl_tb.sv
module adc_ramp_ctrl_tb;

    localparam int W    = 4;
    localparam int S    = 3;
    localparam int SYN  = 2;
    localparam int MAXC = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         cmp_i;
    logic [W-1:0] dac_code_o;
    logic         sample_o, hold_o, busy_o, done_o, pwm_o;
    logic [W-1:0] result_o;

    int live_v = 0;
    int held_v = 0;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // behavioural track-and-hold and comparator
    always @(posedge clk) if (sample_o) held_v <= live_v;
    assign cmp_i = (held_v > int'(dac_code_o));

    adc_ramp_ctrl #(
        .WIDTH (W), .SAMPLE_CLKS (S), .SYNC_STAGES (SYN)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .cmp_i (cmp_i),
        .dac_code_o (dac_code_o), .sample_o (sample_o), .hold_o (hold_o),
        .busy_o (busy_o), .done_o (done_o), .result_o (result_o), .pwm_o (pwm_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic convert(input int v, input bit poke);
        int cyc = 0, pwm_n = 0, smp_n = 0, done_at = 0;
        int smp_bad = 0, hold_bad = 0, dac_bad = 0, busy_bad = 0, res_bad = 0;
        int r, exp_done, exp_dac;
        int prev_res;
        prev_res = int'(result_o);
        r = (v > MAXC) ? MAXC : v;
        exp_done = S + r + 3 + SYN;
        live_v = v;
        @(negedge clk) start_i = 1'b1;
        @(posedge clk);
        while (cyc < 300) begin
            @(negedge clk);
            cyc++;
            start_i = 1'b0;
            if (poke && (cyc == S + 4)) start_i = 1'b1;
            if (cyc == S + 1) live_v = v ^ 5;
            if (sample_o) smp_n++;
            if (sample_o != (cyc <= S)) smp_bad++;
            if (pwm_o) pwm_n++;
            if (!busy_o) busy_bad++;
            if (!done_o && int'(result_o) != prev_res) res_bad++;
            if (done_o) begin
                done_at = cyc;
                break;
            end
            if (hold_o != (cyc > S)) hold_bad++;
            exp_dac = (cyc >= S + 2) ? (((cyc - S - 2) > MAXC) ? MAXC : (cyc - S - 2)) : 0;
            if (int'(dac_code_o) != exp_dac) dac_bad++;
        end
        chk("R8 done cycle", done_at, exp_done);
        chk((v > MAXC) ? "R6 overrange result" : "R5 result", int'(result_o), r);
        chk("R7 pulse width", pwm_n, (v > MAXC + 1) ? MAXC + 1 : v);
        chk("R2 sample width", smp_n, S);
        chk("R2 sample placement", smp_bad, 0);
        chk("R3 hold window", hold_bad + int'(hold_o), 0);
        chk("R4 dac sequence", dac_bad, 0);
        chk("R8 busy during conversion", busy_bad, 0);
        chk("R10 result held until done", res_bad, 0);
        @(negedge clk);
        chk("R8 done single cycle", int'(done_o), 0);
        chk(poke ? "R9 no restart after busy start" : "R8 busy released", int'(busy_o), 0);
        repeat (3) @(negedge clk);
        chk(poke ? "R9 stays idle" : "R10 result kept in idle", int'(busy_o) * 100 + int'(result_o), r);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'({dac_code_o, sample_o, hold_o, busy_o, done_o, result_o, pwm_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle after reset", int'({dac_code_o, sample_o, hold_o, busy_o, done_o, result_o, pwm_o}), 0);
        for (int v = 0; v <= MAXC + 1; v++) convert(v, v[0]);
        convert(25, 1'b1);   // R6 far overrange with start poke
        convert(7, 1'b0);
        convert(0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule